// File: doc/BRIEF.md
# Run-Time Programmable Multi-Width CRC Engine

This block computes a cyclic redundancy check over a stream of data beats. The generator polynomial is an input vector, so a single datapath serves several CRC standards without duplicating feedback logic. A length select chooses between a 32-bit and a 64-bit CRC. A per-beat width select sets how many data bits the beat carries: 8, 16, 32 or 64.

The state register, the polynomial path and the data path are all sized for the widest case. Each beat is processed as an unrolled chain of single-bit shift steps. The feedback bit is taken from the top bit of the active CRC length, and the tap vector is masked to that length. A start strobe restarts the message from an all-zero initial value. No bit reflection or final XOR is applied.

Top module: `crc_engine`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the CRC register is cleared to all zeros (synchronous, active-low reset).
- R2: With `len_sel`=0 (32-bit CRC), every valid beat advances the CRC one bit at a time. For each bit, the feedback is bit 31 of the state XOR the data bit. The state then shifts left, is truncated to 32 bits, and is XORed with `poly[31:0]` when the feedback is 1. This holds for any tap pattern, for example 0x04C11DB7.
- R3: With `len_sel`=1 (64-bit CRC), the same stepping uses bit 63 as the feedback source and the full 64-bit `poly`, for example 0x42F0E1EBA9EA3693.
- R4: `dw_sel` selects the beat width: 0 means 8 bits, 1 means 16, 2 means 32 and 3 means 64. Only the low bits of `data` are used, and they are consumed most significant bit first.
- R5: In 32-bit mode, `crc_out[63:32]` is zero.
- R6: When `valid` and `start` are both low, the CRC register keeps its value.
- R7: `start` high with `valid` low loads all zeros into the CRC register.
- R8: `start` and `valid` high together process the beat starting from an all-zero state, in the same cycle.
- R9: In 32-bit mode, `poly[63:32]` has no effect on the result.
- R10: Data bits above the selected beat width have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Restart the message from an all-zero state |
| valid | input | 1 | The beat on `data` is to be consumed |
| data | input | 64 | Beat data, low bits used, MSB first |
| dw_sel | input | 2 | Beat width: 0=8, 1=16, 2=32, 3=64 |
| len_sel | input | 1 | CRC length: 0=32-bit, 1=64-bit |
| poly | input | 64 | Generator polynomial taps, without the implicit top bit |
| crc_out | output | 64 | Current CRC, masked to the active length |

## Verification
The checker monitors four properties on every cycle:
- the upper half of the output is zero in 32-bit mode;
- the register holds when it is idle;
- a start without a beat clears the register;
- a started all-zero beat leaves the CRC at zero.

The actual CRC values cannot be checked cycle by cycle. Only the bench scenarios show them: randomized messages mixing 8- and 16-bit beats, full-width beats, polynomial and data bits placed outside the active range, and start and reset landing in the middle of a message. Each is compared against a bit-serial model written in the bench.

// File: rtl/crc_pkg.sv
// Package: shared sizes and width-select decode for the CRC engine.
// Assumes the beat-width codes are 0..3, selecting 8 << code bits.
package crc_pkg;
    localparam int unsigned CRC_MAX  = 64;
    localparam int unsigned DATA_MAX = 64;
    localparam int unsigned SEL_W    = 2;
    localparam int unsigned CNT_W    = $clog2(DATA_MAX + 1);

    typedef enum logic {LEN_32 = 1'b0, LEN_64 = 1'b1} crc_len_e;

    // Number of data bits consumed for a given width code.
    function automatic logic [CNT_W-1:0] beat_bits(input logic [SEL_W-1:0] code);
        beat_bits = CNT_W'(8) << code;
    endfunction
endpackage

// File: rtl/crc_len_mask.sv
// Module: builds the length mask and the masked tap vector for the active CRC length.
// Assumes CRC_W is even; the short mode is exactly half of CRC_W.
module crc_len_mask #(
    parameter int unsigned CRC_W = crc_pkg::CRC_MAX
) (
    input  logic             len64,
    input  logic [CRC_W-1:0] poly,
    output logic [CRC_W-1:0] len_mask,
    output logic [CRC_W-1:0] poly_m
);
    localparam int unsigned HALF = CRC_W / 2;

    // Purpose: choose the mask for the active length and apply it to the taps.
    always_comb begin
        len_mask = len64 ? {CRC_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
        poly_m   = poly & len_mask;
    end
endmodule

// File: rtl/crc_bit_step.sv
// Module: one serial CRC step for one input bit.
// Assumes state bits above the active length are already zero.
module crc_bit_step #(
    parameter int unsigned CRC_W = crc_pkg::CRC_MAX
) (
    input  logic             len64,
    input  logic [CRC_W-1:0] state_in,
    input  logic             din,
    input  logic [CRC_W-1:0] len_mask,
    input  logic [CRC_W-1:0] poly_m,
    output logic [CRC_W-1:0] state_out
);
    localparam int unsigned HALF = CRC_W / 2;
    logic fb;

    // Purpose: form the feedback bit, shift, truncate, then apply the taps.
    always_comb begin
        fb        = (len64 ? state_in[CRC_W-1] : state_in[HALF-1]) ^ din;
        state_out = (state_in << 1) & len_mask;
        if (fb) state_out = state_out ^ poly_m;
    end
endmodule

// File: rtl/crc_beat_unroll.sv
// Module: unrolled chain of bit steps covering one full beat.
// Assumes the beat occupies the low bits of data, MSB first. The data is
// left-aligned, and the chain output after the selected number of steps is taken.
module crc_beat_unroll #(
    parameter int unsigned CRC_W  = crc_pkg::CRC_MAX,
    parameter int unsigned DATA_W = crc_pkg::DATA_MAX
) (
    input  logic                      len64,
    input  logic [CRC_W-1:0]          state_in,
    input  logic [DATA_W-1:0]         data,
    input  logic [crc_pkg::SEL_W-1:0] dw_sel,
    input  logic [CRC_W-1:0]          len_mask,
    input  logic [CRC_W-1:0]          poly_m,
    output logic [CRC_W-1:0]          state_out
);
    localparam int unsigned CW = crc_pkg::CNT_W;

    logic [CW-1:0]     nbits;
    logic [DATA_W-1:0] aligned;
    logic [CRC_W-1:0]  chain [DATA_W+1];

    // Purpose: decode the beat width and move the active bits to the top.
    always_comb begin
        nbits   = crc_pkg::beat_bits(dw_sel);
        aligned = data << (CW'(DATA_W) - nbits);
    end

    assign chain[0] = state_in;

    for (genvar k = 0; k < DATA_W; k++) begin : g_step
        crc_bit_step #(.CRC_W(CRC_W)) u_step (
            .len64    (len64),
            .state_in (chain[k]),
            .din      (aligned[DATA_W-1-k]),
            .len_mask (len_mask),
            .poly_m   (poly_m),
            .state_out(chain[k+1])
        );
    end

    // Purpose: select the chain tap that matches the beat width.
    always_comb begin
        state_out = chain[nbits];
    end
endmodule

// File: rtl/crc_engine.sv
// Module: top of the run-time programmable CRC engine.
// Assumes the polynomial and the length select stay stable within a message.
// The output is the state masked to the active length.
module crc_engine #(
    parameter int unsigned CRC_W  = crc_pkg::CRC_MAX,
    parameter int unsigned DATA_W = crc_pkg::DATA_MAX
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      valid,
    input  logic [DATA_W-1:0]         data,
    input  logic [crc_pkg::SEL_W-1:0] dw_sel,
    input  logic                      len_sel,
    input  logic [CRC_W-1:0]          poly,
    output logic [CRC_W-1:0]          crc_out
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] next_state;
    logic [CRC_W-1:0] len_mask;
    logic [CRC_W-1:0] poly_m;
    logic             len64;

    assign len64 = (len_sel == crc_pkg::LEN_64);

    crc_len_mask #(.CRC_W(CRC_W)) u_mask (
        .len64   (len64),
        .poly    (poly),
        .len_mask(len_mask),
        .poly_m  (poly_m)
    );

    // Purpose: the beat starts from zero on start, otherwise from the held state.
    always_comb begin
        seed = start ? '0 : (crc_q & len_mask);
    end

    crc_beat_unroll #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_beat (
        .len64    (len64),
        .state_in (seed),
        .data     (data),
        .dw_sel   (dw_sel),
        .len_mask (len_mask),
        .poly_m   (poly_m),
        .state_out(next_state)
    );

    // Purpose: CRC register with synchronous reset, clear, update and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     crc_q <= '0;
        else if (valid) crc_q <= next_state;
        else if (start) crc_q <= '0;
    end

    // Purpose: present the state sliced to the active length.
    always_comb begin
        crc_out = crc_q & len_mask;
    end
endmodule

// File: rtl/crc_engine_chk.sv
// Module: protocol checker for crc_engine, attached with bind.
module crc_engine_chk #(
    parameter int unsigned CRC_W  = crc_pkg::CRC_MAX,
    parameter int unsigned DATA_W = crc_pkg::DATA_MAX
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic                      valid,
    input logic [DATA_W-1:0]         data,
    input logic [crc_pkg::SEL_W-1:0] dw_sel,
    input logic                      len_sel,
    input logic [CRC_W-1:0]          poly,
    input logic [CRC_W-1:0]          crc_out
);
    localparam int unsigned HALF = CRC_W / 2;

    // R5: the upper half of the output is zero in short mode
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !len_sel |-> crc_out[CRC_W-1:HALF] == '0);

    // R6: an idle cycle keeps the register value
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !start && $stable(len_sel)) |=> $stable(crc_out));

    // R7: a start without a beat clears the register
    a_r7_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !valid) |=> crc_out == '0);

    // R8: a started all-zero beat from the zero seed stays zero
    a_r8_zero_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (start && valid && data == '0) |=> crc_out == '0);
endmodule

bind crc_engine crc_engine_chk #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_crc_engine.sv
// Bench: randomized and directed checks of crc_engine against a bit-serial model.
module tb_crc_engine;
    localparam logic [63:0] P32 = 64'h0000_0000_04C1_1DB7;
    localparam logic [63:0] P64 = 64'h42F0_E1EB_A9EA_3693;

    logic        clk = 1'b0;
    logic        rst_n, start, valid, len_sel;
    logic [63:0] data, poly, crc_out;
    logic [1:0]  dw_sel;
    logic [63:0] exp_crc;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    crc_engine dut (.clk(clk), .rst_n(rst_n), .start(start), .valid(valid), .data(data),
                    .dw_sel(dw_sel), .len_sel(len_sel), .poly(poly), .crc_out(crc_out));

    // Reference model: process one beat one bit at a time.
    function automatic logic [63:0] ref_beat(input logic [63:0] st, input logic [63:0] d,
                                             input logic [1:0] code, input logic is64,
                                             input logic [63:0] p);
        int          w = 8 << code;
        logic [63:0] m = is64 ? '1 : 64'h0000_0000_FFFF_FFFF;
        logic        fb;
        for (int i = w - 1; i >= 0; i--) begin
            fb = (is64 ? st[63] : st[31]) ^ d[i];
            st = (st << 1) & m;
            if (fb) st = st ^ (p & m);
        end
        return st;
    endfunction

    task automatic check(input string req, input logic [63:0] exp);
        n_chk++;
        if (crc_out !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, crc_out, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, then sample at the next falling edge.
    task automatic cycle(input logic s, input logic v, input logic [63:0] d, input logic [1:0] c);
        start = s; valid = v; data = d; dw_sel = c;
        @(negedge clk);
    endtask

    task automatic beat(input string req, input logic s, input logic [63:0] d, input logic [1:0] c);
        exp_crc = ref_beat(s ? 64'h0 : exp_crc, d, c, len_sel, poly);
        cycle(s, 1'b1, d, c);
        check(req, exp_crc);
    endtask

    task automatic message(input string req, input logic is64, input logic [63:0] p,
                           input int nb, input bit mixed);
        logic [1:0] c;
        len_sel = is64; poly = p;
        for (int b = 0; b < nb; b++) begin
            c = mixed ? 2'($urandom_range(0, 1)) : 2'($urandom_range(0, 3));
            beat(req, b == 0, {$urandom, $urandom}, c);
        end
    endtask

    initial begin
        #150000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; start = 1'b0; valid = 1'b0; data = '0; dw_sel = '0;
        len_sel = 1'b0; poly = P32;
        @(negedge clk); @(negedge clk);
        check("R1 reset", 64'h0);
        rst_n = 1'b1;

        // R2: 32-bit mode, mixed 8-bit and 16-bit beats
        for (int m = 0; m < 6; m++) message("R2", 1'b0, P32, 12, 1'b1);
        // R3: 64-bit mode, mixed 8-bit and 16-bit beats
        for (int m = 0; m < 6; m++) message("R3", 1'b1, P64, 12, 1'b1);
        // R4: all four beat widths
        for (int m = 0; m < 4; m++) message("R4", m[0], m[0] ? P64 : P32, 10, 1'b0);
        // R2: other tap patterns work as well
        message("R2 alt poly", 1'b0, 64'h0000_0000_1EDC_6F41, 8, 1'b0);

        // R4: single-byte directed value, MSB first
        len_sel = 1'b0; poly = P32;
        beat("R4 msb first", 1'b1, 64'h0000_0000_0000_0080, 2'd0);

        // R5: upper output bits zero in 32-bit mode
        beat("R5 upper zero", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3);
        n_chk++;
        if (crc_out[63:32] !== 32'h0) begin
            n_fail++;
            $display("FAIL R5 actual=%h expected=0", crc_out[63:32]);
        end

        // R9: garbage in the upper poly bits has no effect in 32-bit mode
        poly = 64'hDEAD_BEEF_0000_0000 | P32;
        beat("R9 upper poly", 1'b0, 64'h0000_0000_0000_A55A, 2'd1);
        beat("R9 upper poly", 1'b0, 64'h1234_5678_9ABC_DEF0, 2'd3);
        poly = P32;

        // R10: high data bits above the width are ignored
        exp_crc = ref_beat(exp_crc, 64'h0000_0000_0000_0033, 2'd0, 1'b0, P32);
        cycle(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FF33, 2'd0);
        check("R10 high data ignored", exp_crc);

        // R6: hold while idle, with data and width toggling
        cycle(1'b0, 1'b0, 64'hAAAA_5555_AAAA_5555, 2'd3);
        check("R6 hold", exp_crc);
        cycle(1'b0, 1'b0, 64'h0123_4567_89AB_CDEF, 2'd1);
        check("R6 hold", exp_crc);

        // R7: start without valid clears
        cycle(1'b1, 1'b0, 64'hFFFF, 2'd1);
        exp_crc = '0;
        check("R7 start clear", exp_crc);

        // R8: start with valid restarts in the middle of a message
        len_sel = 1'b1; poly = P64;
        beat("R8 pre", 1'b0, 64'h0000_0000_0000_00C3, 2'd0);
        beat("R8 start+valid", 1'b1, 64'h0000_0000_0000_BEEF, 2'd1);

        // R1: reset in the middle of a message
        rst_n = 1'b0;
        cycle(1'b0, 1'b1, 64'h77, 2'd0);
        check("R1 mid reset", 64'h0);
        rst_n = 1'b1;
        cycle(1'b0, 1'b0, 64'h0, 2'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule